// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block turns a stream of stereo sample pairs into one or more self-clocking serial lines of the kind used by consumer and professional digital audio links. Each pair becomes a frame of two subframes (first slot carries the left sample, second slot the right sample). Every subframe is 32 time slots long: a 4-slot sync preamble, 24 audio bits sent LSB first, then validity, user, channel-status and parity bits. The result is sent with biphase-mark coding, so the receiver recovers both the bit clock and the frame boundaries from the line itself.

The encoder is clocked at twice the bit rate, one half-bit cell per clock, so a subframe lasts 64 clocks and a frame 128 clocks. Two 384-bit stores, one for channel status and one for user data, are loaded 32 bits at a time through a plain write port. They supply one bit per subframe across a 192-frame block. Two static pins give the validity bit for first and second subframes. With several lanes, every lane carries its own audio but shares timing, preambles and the validity, user and status bits.

Samples enter over valid/ready. Behind the port sits a single holding slot. `in_ready` is high while that slot is empty. A pair is taken on any rising edge where `in_valid` and `in_ready` are both high, and the source must hold its data until then. The held pair moves into transmission at the last cell of the current frame, and ready returns at that point. If no pair is held when a frame begins, that frame carries silence and the line keeps running.

Top module: `bmark_tx`

## Requirements
- R1: One clock is one half-bit cell. In every data slot (slots 4 to 31 of a subframe), the line toggles at the start of the slot. It toggles again at mid-slot only when the bit is 1.
- R2: Slots 4 to 27 carry the 24 audio bits, bit 0 first. Slot 28 is validity, slot 29 is user, slot 30 is channel status and slot 31 is parity. The first subframe of a frame carries the left word and the second carries the right word.
- R3: Slots 0 to 3 form 8 preamble cells. If the line sat low before the preamble, the cells are 11101000 (B) for the first subframe of frame 0 of each 192-frame block, 11100010 (M) for other first subframes, and 11100100 (W) for second subframes. If the line sat high before the preamble, the pattern is inverted.
- R4: Parity makes slots 4 to 31 hold an even number of ones. As a result, the line level at every subframe start equals the level after reset (low).
- R5: The validity bit is `val_first` in first subframes and `val_second` in second subframes.
- R6: The user bit and the status bit of a subframe come from store index 2*frame+sub, where frame is 0 to 191 and sub is 0 or 1. A write with `cfg_sel`=0 loads the status store and `cfg_sel`=1 loads the user store. `cfg_data` bit j goes to index 32*`cfg_addr`+j. Writes take effect on the next edge, are accepted during reset, and addresses 12 to 15 are ignored.
- R7: `in_ready` is low exactly while a pair is held. After an accepted transfer, ready is low on the next cycle. It rises only after the last cell (cell 127) of a frame.
- R8: A frame that starts with no pair held sends zero audio in both subframes. Timing, preambles and the other bits are unaffected.
- R9: All lanes carry identical preambles and identical validity, user and status bits. Lane k audio is bits [24k+23:24k] of `in_left`/`in_right`.
- R10: During reset the line is low and `in_ready` is high. The first edge after reset produces cell 0 of frame 0, which is a B preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit cell clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding slot empty, pair can be taken |
| in_left | input | LANES*24 | Left (first subframe) word per lane |
| in_right | input | LANES*24 | Right (second subframe) word per lane |
| val_first | input | 1 | Validity bit for first subframes |
| val_second | input | 1 | Validity bit for second subframes |
| cfg_we | input | 1 | Store word write strobe |
| cfg_sel | input | 1 | 0 status store, 1 user store |
| cfg_addr | input | 4 | Store word index |
| cfg_data | input | 32 | Store word value |
| line_out | output | LANES | Biphase-mark coded line, one per lane |

## Verification
The bench decodes the lines cell by cell and goes after the block wrap from frame 191 to 0. A wrong frame counter there would send M where B is due, or pick user and status bits from the wrong index. It stalls the source for several frames and offers a pair in the same cycle a frame ends. A broken holding slot would then repeat or drop a pair, or fill an underrun frame with stale audio instead of silence. It uses all-ones, alternating and random words on two lanes and rewrites store words while frames are running. This exposes parity errors, where the next preamble starts at the wrong polarity, and lanes that drift apart in their side bits.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int AUDIO_W          = 24;
  localparam int POS_W            = 7;   // 128 cells per frame
  localparam int FRAMES_PER_BLOCK = 192;
  localparam int FRAME_W          = $clog2(FRAMES_PER_BLOCK);
  localparam int STORE_BITS       = 2 * FRAMES_PER_BLOCK;
  localparam int STORE_IDX_W      = $clog2(STORE_BITS);
  localparam int CFG_WORD_W       = 32;
  localparam int CFG_WORDS        = STORE_BITS / CFG_WORD_W;
  localparam int CFG_ADDR_W       = 4;
  localparam int SLOT_AUDIO0      = 4;
  localparam int SLOT_V           = 28;
  localparam int SLOT_U           = 29;
  localparam int SLOT_C           = 30;
  localparam int SLOT_P           = 31;

  typedef enum logic [1:0] {SYNC_BLOCK, SYNC_FIRST, SYNC_SECOND} sync_kind_e;

  // cell 0 is bit 7; values assume the line sat low before the preamble
  function automatic logic [7:0] sync_cells(sync_kind_e k);
    case (k)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_FIRST: return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmt_bitstore.sv
module bmt_bitstore
  import bmt_pkg::*;
#(
  parameter int WORDS = CFG_WORDS,
  parameter int WW    = CFG_WORD_W,
  parameter int AW    = CFG_ADDR_W,
  parameter int IW    = STORE_IDX_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic          rbit
);
  localparam int NBITS = WORDS * WW;

  logic [NBITS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < WORDS)) bits_q[int'(waddr)*WW +: WW] <= wdata;
  end

  assign rbit = (int'(ridx) < NBITS) ? bits_q[ridx] : 1'b0;
endmodule

// File: rtl/bmt_timebase.sv
module bmt_timebase
  import bmt_pkg::*;
#(
  parameter int DW = 2 * AUDIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      in_left,
  input  logic [DW-1:0]      in_right,
  output logic [POS_W-1:0]   pos,
  output logic [FRAME_W-1:0] frame,
  output logic [DW-1:0]      cur_left,
  output logic [DW-1:0]      cur_right
);
  logic          held_q;
  logic [DW-1:0] hold_l_q, hold_r_q;
  logic          last_cell;

  assign last_cell = (pos == '1);
  assign in_ready  = !held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      frame     <= '0;
      held_q    <= 1'b0;
      hold_l_q  <= '0;
      hold_r_q  <= '0;
      cur_left  <= '0;
      cur_right <= '0;
    end else begin
      pos <= pos + 1'b1;
      if (last_cell) begin
        frame     <= (frame == FRAME_W'(FRAMES_PER_BLOCK - 1)) ? '0 : frame + 1'b1;
        cur_left  <= held_q ? hold_l_q : '0;
        cur_right <= held_q ? hold_r_q : '0;
        held_q    <= 1'b0;
      end
      if (in_valid && in_ready) begin
        hold_l_q <= in_left;
        hold_r_q <= in_right;
        held_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bmt_lane_enc.sv
module bmt_lane_enc
  import bmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [POS_W-1:0]   pos,
  input  logic               blk_start,
  input  logic [AUDIO_W-1:0] aud_first,
  input  logic [AUDIO_W-1:0] aud_second,
  input  logic               v_bit,
  input  logic               u_bit,
  input  logic               c_bit,
  output logic               line
);
  logic [5:0]         sf_cell;
  logic [4:0]         slot;
  logic [4:0]         aidx;
  logic               half, sub;
  logic [AUDIO_W-1:0] aud;
  logic               data_bit, par_q, base_q, base_now, pat_bit, nxt;
  sync_kind_e         kind;
  logic [7:0]         pat;

  assign sf_cell = pos[5:0];
  assign sub     = pos[6];
  assign slot    = sf_cell[5:1];
  assign half    = sf_cell[0];
  assign aud     = sub ? aud_second : aud_first;
  assign aidx    = slot - 5'(SLOT_AUDIO0);

  always_comb begin
    case (slot)
      5'(SLOT_V): data_bit = v_bit;
      5'(SLOT_U): data_bit = u_bit;
      5'(SLOT_C): data_bit = c_bit;
      5'(SLOT_P): data_bit = par_q;
      default:    data_bit = (aidx < 5'(AUDIO_W)) ? aud[aidx] : 1'b0;
    endcase
  end

  assign kind     = sub ? SYNC_SECOND : (blk_start ? SYNC_BLOCK : SYNC_FIRST);
  assign pat      = sync_cells(kind);
  assign pat_bit  = pat[3'd7 - sf_cell[2:0]];
  assign base_now = (sf_cell == '0) ? line : base_q;

  always_comb begin
    if (sf_cell < 6'd8) nxt = pat_bit ^ base_now;
    else if (!half)     nxt = !line;
    else                nxt = data_bit ? !line : line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line   <= 1'b0;
      base_q <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      line   <= nxt;
      base_q <= base_now;
      if (!half && slot >= 5'(SLOT_AUDIO0) && slot < 5'(SLOT_P))
        par_q <= ((slot == 5'(SLOT_AUDIO0)) ? 1'b0 : par_q) ^ data_bit;
    end
  end
endmodule

// File: rtl/bmark_tx.sv
module bmark_tx
  import bmt_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*AUDIO_W-1:0] in_left,
  input  logic [LANES*AUDIO_W-1:0] in_right,
  input  logic                     val_first,
  input  logic                     val_second,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [CFG_ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_WORD_W-1:0]    cfg_data,
  output logic [LANES-1:0]         line_out
);
  localparam int DW = LANES * AUDIO_W;

  logic [POS_W-1:0]       pos_q;
  logic [FRAME_W-1:0]     frame_q;
  logic [DW-1:0]          cur_l, cur_r;
  logic [STORE_IDX_W-1:0] side_idx;
  logic                   u_bit, c_bit, v_bit, blk_start;

  bmt_timebase #(.DW(DW)) u_time (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .pos(pos_q), .frame(frame_q),
    .cur_left(cur_l), .cur_right(cur_r)
  );

  assign side_idx  = {frame_q, pos_q[6]};
  assign v_bit     = pos_q[6] ? val_second : val_first;
  assign blk_start = (frame_q == '0);

  bmt_bitstore u_status (
    .clk(clk), .we(cfg_we && !cfg_sel), .waddr(cfg_addr), .wdata(cfg_data),
    .ridx(side_idx), .rbit(c_bit)
  );

  bmt_bitstore u_user (
    .clk(clk), .we(cfg_we && cfg_sel), .waddr(cfg_addr), .wdata(cfg_data),
    .ridx(side_idx), .rbit(u_bit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bmt_lane_enc u_enc (
      .clk(clk), .rst_n(rst_n), .pos(pos_q), .blk_start(blk_start),
      .aud_first(cur_l[g*AUDIO_W +: AUDIO_W]),
      .aud_second(cur_r[g*AUDIO_W +: AUDIO_W]),
      .v_bit(v_bit), .u_bit(u_bit), .c_bit(c_bit), .line(line_out[g])
    );
  end
endmodule

// File: rtl/bmark_tx_chk.sv
module bmark_tx_chk
  import bmt_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [POS_W-1:0] pos,
  input logic [LANES-1:0] line
);
  p_boundary_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[5:0] >= 6'd8 && !pos[0]) |=> (line == ~$past(line)));

  p_preamble_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[5:0] == 6'd3) |-> (line == $past(line) && $past(line) == $past(line, 2)));

  p_even_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[5:0] == 6'd0) |-> (line == '0));

  p_accept_clears_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_rises_at_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(pos) == '1));
endmodule

bind bmark_tx bmark_tx_chk #(.LANES(LANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pos(pos_q), .line(line_out)
);

// File: tb/test_bmark_tx.sv
module test_bmark_tx;
  import bmt_pkg::*;
  localparam int LANES = 2;
  localparam int DW    = LANES * AUDIO_W;
  localparam int END_E = 128 * 196;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, in_ready, val_first = 1'b0, val_second = 1'b0;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [CFG_ADDR_W-1:0] cfg_addr = '0;
  logic [CFG_WORD_W-1:0] cfg_data = '0;
  logic [LANES-1:0] line_out;

  bmark_tx #(.LANES(LANES)) i_bmark_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .val_first(val_first),
    .val_second(val_second), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .line_out(line_out)
  );

  int checks = 0, errors = 0, edge_n = 0, mon_e;
  bit run = 0, fin = 0;
  logic [STORE_BITS-1:0] m_cs = '0, m_us = '0;
  int q_h[$];
  logic [DW-1:0] q_l[$], q_r[$];
  logic [DW-1:0] exp_l = '0, exp_r = '0;
  bit exp_silent = 1;
  logic [LANES-1:0] cells [64];
  logic [LANES-1:0] prev_lv = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input int addr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = CFG_ADDR_W'(addr); cfg_data = d;
    if (addr < CFG_WORDS) begin
      if (sel) m_us[addr*32 +: 32] = d;
      else     m_cs[addr*32 +: 32] = d;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // scoreboard monitor: decode one subframe of cells per lane
  task automatic decode_sf(input int sfi);
    int f, sub, idx;
    logic [7:0] pat, seen;
    logic [27:0] bits;
    logic [23:0] aexp;
    bit bnd_ok;
    f = sfi / 2; sub = sfi % 2;
    if (sub == 0) begin
      if (q_h.size() > 0 && q_h[0] < 128 * f - 1) begin
        void'(q_h.pop_front());
        exp_l = q_l.pop_front(); exp_r = q_r.pop_front(); exp_silent = 0;
      end else begin
        exp_l = '0; exp_r = '0; exp_silent = 1;
      end
    end
    idx = (f % FRAMES_PER_BLOCK) * 2 + sub;
    pat = sync_cells(sub ? SYNC_SECOND : ((f % FRAMES_PER_BLOCK == 0) ? SYNC_BLOCK : SYNC_FIRST));
    for (int ln = 0; ln < LANES; ln++) begin
      for (int k = 0; k < 8; k++) seen[7-k] = cells[k][ln];
      chk(seen == (pat ^ {8{prev_lv[ln]}}), "R3", "preamble cells", 32'(seen),
          32'(pat ^ {8{prev_lv[ln]}}));
      bnd_ok = 1;
      for (int s = 4; s < 32; s++) begin
        if (cells[2*s][ln] == cells[2*s-1][ln]) bnd_ok = 0;
        bits[s-4] = cells[2*s][ln] ^ cells[2*s+1][ln];
      end
      chk(bnd_ok, "R1", "slot boundary toggle", 32'(bnd_ok), 32'd1);
      aexp = sub ? exp_r[ln*AUDIO_W +: AUDIO_W] : exp_l[ln*AUDIO_W +: AUDIO_W];
      chk(bits[23:0] == aexp, exp_silent ? "R8" : "R2", "audio word", 32'(bits[23:0]), 32'(aexp));
      chk(bits[24] == (sub ? val_second : val_first), "R5", "validity",
          32'(bits[24]), 32'(sub ? val_second : val_first));
      chk(bits[25] == m_us[idx], "R6", "user bit", 32'(bits[25]), 32'(m_us[idx]));
      chk(bits[26] == m_cs[idx], (ln == 0) ? "R6" : "R9", "status bit", 32'(bits[26]), 32'(m_cs[idx]));
      chk(^bits == 1'b0, "R4", "even parity", 32'(^bits), 32'd0);
    end
    prev_lv = cells[63];
  endtask

  always @(posedge clk) if (run) edge_n++;

  always @(negedge clk) begin
    if (run && !fin && edge_n > 0) begin
      mon_e = edge_n - 1;
      cells[mon_e % 64] = line_out;
      if (mon_e % 64 == 63) decode_sf(mon_e / 64);
    end
  end

  // validity pattern changes early in every 8th frame
  always @(negedge clk) begin
    if (run && edge_n % 128 == 4 && (edge_n / 128) % 8 == 0)
      {val_first, val_second} = 2'((edge_n / 1024) % 4);
  end

  // driver: offers pairs, holds data while stalled, pushes expected items
  initial begin : driver
    int n;
    logic [DW-1:0] l, r;
    n = 0;
    wait (run);
    while (edge_n < END_E) begin
      case (n)
        1:       begin l = '1; r = '1; end
        2:       begin l = {LANES{24'h555555}}; r = {LANES{24'hAAAAAA}}; end
        default: begin l = {$urandom, $urandom}; r = {$urandom, $urandom}; end
      endcase
      if (n % 7 == 3) begin
        while (edge_n % 128 != 127) @(negedge clk);
      end
      in_valid = 1'b1; in_left = l; in_right = r;
      while (!in_ready) @(negedge clk);
      q_h.push_back(edge_n); q_l.push_back(l); q_r.push_back(r);
      @(negedge clk);
      chk(!in_ready, "R7", "ready low after accept", 32'(in_ready), 32'd0);
      if (n == 20) begin
        in_valid = 1'b0;
        repeat (128 * 3) @(negedge clk);
      end
      n++;
    end
    in_valid = 1'b0;
  end

  initial begin : watchdog
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", edge_n, END_E);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    for (int w = 0; w < CFG_WORDS; w++) begin
      cfg_write(1'b0, w, 32'h3C5A0F01 ^ (32'(w) * 32'h01030507));
      cfg_write(1'b1, w, $urandom);
    end
    cfg_write(1'b0, 14, 32'hFFFFFFFF);  // out-of-range address ignored (R6)
    chk(in_ready == 1'b1, "R10", "ready in reset", 32'(in_ready), 32'd1);
    chk(line_out == '0, "R10", "line in reset", 32'(line_out), 32'd0);
    @(negedge clk);
    rst_n = 1'b1; run = 1;
    @(negedge clk);
    chk(line_out == {LANES{1'b1}}, "R10", "first cell after reset", 32'(line_out), 32'(LANES == 2 ? 3 : 1));
    while (edge_n < 128 * 40 + 8) @(negedge clk);
    cfg_write(1'b1, 11, 32'hF0F0_1234);
    cfg_write(1'b0, 0, 32'h8001_7FFE);
    while (edge_n < END_E) @(negedge clk);
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule